// File: doc/BRIEF.md
# Subsystem System Control Register File

This block is the control and status register file of a small dual-core secure microcontroller subsystem. Software reaches it over a plain 32-bit register bus (select, write enable, byte strobes, address, write data, registered read data) that decodes a 4 KB window. It holds the boot settings for each core: the initial vector-table offsets, the per-core boot-hold bits and a lockable vector register for core 0. It also holds the reset cause and reset mask, a retention word that survives warm resets, a secure-debug state with separate set and clear ports, clock divider and clock force words, a lockable power-control word, the power-domain sense words and twelve fixed identification words.

Side effects leave the block on its outputs. A single-cycle software reset request goes to the reset controller. A single-cycle release strobe goes to a core when its hold bit drops. The live vector offsets go to the cores. Accesses that hit no register, or that write a read-only word, raise a one-cycle error flag.

Top module: `subsys_sysctl`

## Requirements
- R1: After reset, the reset-cause word (0x100) reads 1, the system sense word (0x200) reads 0x7F, the other sense words (0x204, 0x20C, 0x210, 0x214, 0x218) read 0, the power-control word (0x120) reads 1, and the vector words (0x110, 0x114) and the boot-hold word (0x118) read their parameter reset values.
- R2: The core-0 vector word (0x110) has a lock bit at bit 0. Once that bit is 1, writes to the word are ignored until the warm reset. The core-0 offset output carries bits 31:7 of the word, with bits 6:0 forced to zero.
- R3: A write to 0x004 ORs the data into the secure-debug state. A write to 0x008 clears each state bit written as 1. The state reads at 0x000.
- R4: A write to 0x108 with data bit 9 set raises the software reset request for exactly one cycle. Other data bits have no effect, and 0x108 reads 0.
- R5: For each core i, a write to 0x118 that takes bit i from 1 to 0 drives release bit i high for one cycle. No other write to 0x118 produces a release.
- R6: A write to 0x120 takes effect only while bit 0 of its current value is 1. Bit 1 is the access-filter control.
- R7: The read-only identification words at 0xFD0 to 0xFFC read in address order 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R8: A write replaces the whole 32-bit word. Byte lanes whose strobe is 0 are written as zero, and a read returns the full word whatever the strobes are.
- R9: The words at 0x014, 0x018, 0x104, 0x10C, 0x114, 0x11C and the sense words read back the last value written.
- R10: The retention word (0x10C) keeps its value through the warm reset (rstN) and is cleared only by the power-on reset (porN).
- R11: Reads of write-only or unmapped offsets return 0. The error flag pulses for one cycle on any access to an unmapped offset and on a write to 0x000 or to an identification word. A rejected write changes nothing.
- R12: Read data and the error flag are registered. They show the result of an access in the cycle after it and return to 0 when the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstN | input | 1 | Warm reset, active low, asynchronous |
| busSel | input | 1 | Access valid this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 12 | Byte offset within the 4 KB window |
| busBe | input | 4 | Byte-lane strobes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | One-cycle access error flag |
| swResetReq | output | 1 | One-cycle software reset request |
| coreRelease | output | NUM_CORES | One-cycle per-core release strobes |
| core0VecOff | output | 32 | Core-0 vector offset (bits 6:0 zero) |
| core1VecOff | output | 32 | Core-1 vector offset |

## Verification
A vector table drives reads of every reset value and identification word, write-then-read pairs on the plain words, and partial-strobe writes. Reading after a partial-strobe write shows whether unselected lanes are zeroed or merged. Set and clear sequences on the debug state show whether OR and clear-on-one semantics are kept apart. Writes after each lock bit is set show whether the lock holds. Directed sequences on the boot-hold word cover a drop of each core's bit, a raise, and a rewrite of zero, which separates true falling edges from level-0 writes. Warm and power-on resets are applied in turn to show that the retention word follows only the power-on reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int REGION_W  = 12;
  localparam int DATA_W    = 32;
  localparam int BE_W      = DATA_W / 8;
  localparam int SENSE_CNT = 6;
  localparam int IDX_W     = 4;
  localparam int SWRST_BIT = 9;

  typedef enum logic [4:0] {
    REG_NONE,
    REG_DBG_STAT,
    REG_DBG_SET,
    REG_DBG_CLR,
    REG_CLK_DIV,
    REG_CLK_FORCE,
    REG_CAUSE,
    REG_RMASK,
    REG_SWRST,
    REG_RETAIN,
    REG_VEC0,
    REG_VEC1,
    REG_HOLD,
    REG_NMI,
    REG_PWR,
    REG_SENSE,
    REG_ID
  } regSel_e;

  typedef struct packed {
    logic         wrEn;
    logic         rdEn;
    regSel_e      target;
    logic [IDX_W-1:0] idx;
  } regStrobe_t;

  function automatic logic [7:0] idWord(input logic [IDX_W-1:0] i);
    logic [7:0] v;
    case (i)
      4'd0:  v = 8'h04;
      4'd4:  v = 8'h54;
      4'd5:  v = 8'hB8;
      4'd6:  v = 8'h1B;
      4'd8:  v = 8'h0D;
      4'd9:  v = 8'hF0;
      4'd10: v = 8'h05;
      4'd11: v = 8'hB1;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [REGION_W-1:0] busAddr,
  output regStrobe_t          strb,
  output logic                errFlag
);

  localparam logic [REGION_W-1:0] ID_BASE = 12'hFD0;

  logic [REGION_W-1:0] wordAddr;
  logic [REGION_W-1:0] idOff;
  regSel_e             target;
  logic [IDX_W-1:0]    idx;
  logic                readOnly;
  logic                unmapped;

  assign wordAddr = {busAddr[REGION_W-1:2], 2'b00};
  assign idOff    = wordAddr - ID_BASE;

  always_comb begin
    target   = REG_NONE;
    idx      = '0;
    readOnly = 1'b0;
    case (wordAddr)
      12'h000: begin target = REG_DBG_STAT; readOnly = 1'b1; end
      12'h004: target = REG_DBG_SET;
      12'h008: target = REG_DBG_CLR;
      12'h014: target = REG_CLK_DIV;
      12'h018: target = REG_CLK_FORCE;
      12'h100: target = REG_CAUSE;
      12'h104: target = REG_RMASK;
      12'h108: target = REG_SWRST;
      12'h10C: target = REG_RETAIN;
      12'h110: target = REG_VEC0;
      12'h114: target = REG_VEC1;
      12'h118: target = REG_HOLD;
      12'h11C: target = REG_NMI;
      12'h120: target = REG_PWR;
      12'h200: begin target = REG_SENSE; idx = 4'd0; end
      12'h204: begin target = REG_SENSE; idx = 4'd1; end
      12'h20C: begin target = REG_SENSE; idx = 4'd2; end
      12'h210: begin target = REG_SENSE; idx = 4'd3; end
      12'h214: begin target = REG_SENSE; idx = 4'd4; end
      12'h218: begin target = REG_SENSE; idx = 4'd5; end
      default: begin
        if (wordAddr >= ID_BASE) begin
          target   = REG_ID;
          idx      = idOff[IDX_W+1:2];
          readOnly = 1'b1;
        end
      end
    endcase
  end

  assign unmapped    = (target == REG_NONE);
  assign strb.target = target;
  assign strb.idx    = idx;
  assign strb.wrEn   = busSel && busWr && !readOnly && !unmapped;
  assign strb.rdEn   = busSel && !busWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= busSel && (unmapped || (busWr && readOnly));
  end

endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int                NUM_CORES = 2,
  parameter logic [DATA_W-1:0] VEC0_RST  = 32'h1000_0000,
  parameter logic [DATA_W-1:0] VEC1_RST  = 32'h1000_0000,
  parameter logic [NUM_CORES-1:0] HOLD_RST = '0
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic [BE_W-1:0]      busBe,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 swResetReq,
  output logic [NUM_CORES-1:0] coreRelease,
  output logic [DATA_W-1:0]    vec0Word,
  output logic [DATA_W-1:0]    vec1Word,
  output logic [DATA_W-1:0]    pwrWord
);

  localparam logic [DATA_W-1:0] CAUSE_RST = 32'h1;
  localparam logic [DATA_W-1:0] PWR_RST   = 32'h1;

  logic [DATA_W-1:0] wdm;
  logic [DATA_W-1:0] dbgQ, clkDivQ, clkForceQ, causeQ, rmaskQ;
  logic [DATA_W-1:0] retainQ, nmiQ;
  logic [NUM_CORES-1:0] holdQ;
  logic [DATA_W-1:0] senseQ [SENSE_CNT];
  logic [DATA_W-1:0] rdMux;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign wdm[b*8 +: 8] = busBe[b] ? busWdata[b*8 +: 8] : 8'h00;
  end

  function automatic logic hit(input regStrobe_t s, input regSel_e r);
    return s.wrEn && (s.target == r);
  endfunction

  // Plain read/write words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkDivQ   <= '0;
      clkForceQ <= '0;
      causeQ    <= CAUSE_RST;
      rmaskQ    <= '0;
      nmiQ      <= '0;
      vec1Word  <= VEC1_RST;
    end else begin
      if (hit(strb, REG_CLK_DIV))   clkDivQ   <= wdm;
      if (hit(strb, REG_CLK_FORCE)) clkForceQ <= wdm;
      if (hit(strb, REG_CAUSE))     causeQ    <= wdm;
      if (hit(strb, REG_RMASK))     rmaskQ    <= wdm;
      if (hit(strb, REG_NMI))       nmiQ      <= wdm;
      if (hit(strb, REG_VEC1))      vec1Word  <= wdm;
    end
  end

  // Retention word: power-on reset only
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                    retainQ <= '0;
    else if (hit(strb, REG_RETAIN)) retainQ <= wdm;
  end

  // Secure debug state: set port ORs, clear port clears ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       dbgQ <= '0;
    else if (hit(strb, REG_DBG_SET)) dbgQ <= dbgQ | wdm;
    else if (hit(strb, REG_DBG_CLR)) dbgQ <= dbgQ & ~wdm;
  end

  // Lockable words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vec0Word <= VEC0_RST;
      pwrWord  <= PWR_RST;
    end else begin
      if (hit(strb, REG_VEC0) && !vec0Word[0]) vec0Word <= wdm;
      if (hit(strb, REG_PWR) && pwrWord[0])    pwrWord  <= wdm;
    end
  end

  // Software reset trigger
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swResetReq <= 1'b0;
    else       swResetReq <= hit(strb, REG_SWRST) && wdm[SWRST_BIT];
  end

  // Boot hold bits and per-core release strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    holdQ <= HOLD_RST;
    else if (hit(strb, REG_HOLD)) holdQ <= wdm[NUM_CORES-1:0];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) coreRelease[c] <= 1'b0;
      else       coreRelease[c] <= hit(strb, REG_HOLD) && holdQ[c] && !wdm[c];
    end
  end

  // Power-domain sense words
  for (genvar s = 0; s < SENSE_CNT; s++) begin : g_sense
    localparam logic [DATA_W-1:0] SENSE_RST = (s == 0) ? 32'h7F : 32'h0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) senseQ[s] <= SENSE_RST;
      else if (hit(strb, REG_SENSE) && (int'(strb.idx) == s)) senseQ[s] <= wdm;
    end
  end

  // Read path
  always_comb begin
    rdMux = '0;
    case (strb.target)
      REG_DBG_STAT:  rdMux = dbgQ;
      REG_CLK_DIV:   rdMux = clkDivQ;
      REG_CLK_FORCE: rdMux = clkForceQ;
      REG_CAUSE:     rdMux = causeQ;
      REG_RMASK:     rdMux = rmaskQ;
      REG_RETAIN:    rdMux = retainQ;
      REG_VEC0:      rdMux = vec0Word;
      REG_VEC1:      rdMux = vec1Word;
      REG_HOLD:      rdMux = DATA_W'(holdQ);
      REG_NMI:       rdMux = nmiQ;
      REG_PWR:       rdMux = pwrWord;
      REG_SENSE: begin
        for (int s = 0; s < SENSE_CNT; s++)
          if (int'(strb.idx) == s) rdMux = senseQ[s];
      end
      REG_ID:        rdMux = DATA_W'(idWord(strb.idx));
      default:       rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= strb.rdEn ? rdMux : '0;
  end

endmodule

// File: rtl/subsys_sysctl.sv
module subsys_sysctl
  import sysctl_pkg::*;
#(
  parameter int                NUM_CORES = 2,
  parameter logic [DATA_W-1:0] VEC0_RST  = 32'h1000_0000,
  parameter logic [DATA_W-1:0] VEC1_RST  = 32'h1000_0000,
  parameter logic [NUM_CORES-1:0] HOLD_RST = '0
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [REGION_W-1:0]  busAddr,
  input  logic [BE_W-1:0]      busBe,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 busErr,
  output logic                 swResetReq,
  output logic [NUM_CORES-1:0] coreRelease,
  output logic [DATA_W-1:0]    core0VecOff,
  output logic [DATA_W-1:0]    core1VecOff
);

  localparam logic [DATA_W-1:0] VEC0_MASK = {{(DATA_W-7){1'b1}}, 7'b0};

  regStrobe_t        strb;
  logic [DATA_W-1:0] vec0Word;
  logic [DATA_W-1:0] pwrWord;

  sysctl_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb),
    .errFlag (busErr)
  );

  sysctl_dp #(
    .NUM_CORES (NUM_CORES),
    .VEC0_RST  (VEC0_RST),
    .VEC1_RST  (VEC1_RST),
    .HOLD_RST  (HOLD_RST)
  ) u_dp (
    .clk         (clk),
    .porN        (porN),
    .rstN        (rstN),
    .strb        (strb),
    .busBe       (busBe),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .swResetReq  (swResetReq),
    .coreRelease (coreRelease),
    .vec0Word    (vec0Word),
    .vec1Word    (core1VecOff),
    .pwrWord     (pwrWord)
  );

  assign core0VecOff = vec0Word & VEC0_MASK;

endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker
  import sysctl_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input logic                 clk,
  input logic                 porN,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWr,
  input logic [REGION_W-1:0]  busAddr,
  input logic [BE_W-1:0]      busBe,
  input logic [DATA_W-1:0]    busWdata,
  input logic                 busErr,
  input logic                 swResetReq,
  input logic [NUM_CORES-1:0] coreRelease,
  input logic [DATA_W-1:0]    vec0Word,
  input logic [DATA_W-1:0]    pwrWord
);

  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rstN || !porN)
    vec0Word[0] |=> $stable(vec0Word));

  p_pwr_lock_r6: assert property (@(posedge clk) disable iff (!rstN || !porN)
    !pwrWord[0] |=> $stable(pwrWord));

  p_swrst_src_r4: assert property (@(posedge clk) disable iff (!rstN || !porN)
    swResetReq |-> $past(busSel && busWr && (busAddr[REGION_W-1:2] == 10'h042)
                         && busBe[1] && busWdata[SWRST_BIT]));

  p_swrst_pulse_r4: assert property (@(posedge clk) disable iff (!rstN || !porN)
    swResetReq |=> !swResetReq);

  p_release_src_r5: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (|coreRelease) |-> $past(busSel && busWr && (busAddr[REGION_W-1:2] == 10'h046)));

  p_release_pulse_r5: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (|coreRelease) |=> ((coreRelease & $past(coreRelease)) == '0));

  p_err_src_r11: assert property (@(posedge clk) disable iff (!rstN || !porN)
    busErr |-> $past(busSel));

endmodule

bind subsys_sysctl sysctl_checker #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk         (clk),
  .porN        (porN),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWr       (busWr),
  .busAddr     (busAddr),
  .busBe       (busBe),
  .busWdata    (busWdata),
  .busErr      (busErr),
  .swResetReq  (swResetReq),
  .coreRelease (coreRelease),
  .vec0Word    (vec0Word),
  .pwrWord     (pwrWord)
);

// File: tb/sim_subsys_sysctl.sv
`timescale 1ns/1ps
module sim_subsys_sysctl;

  localparam int NC = 2;
  localparam logic [31:0] V0R = 32'h1000_0000;
  localparam logic [31:0] V1R = 32'h1000_2000;
  localparam logic [NC-1:0] HR = 2'b10;

  logic clk = 1'b0;
  logic porN = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busErr, swResetReq;
  logic [NC-1:0] coreRelease;
  logic [31:0] core0VecOff, core1VecOff;

  int nChecks = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  subsys_sysctl #(.NUM_CORES(NC), .VEC0_RST(V0R), .VEC1_RST(V1R), .HOLD_RST(HR)) u0 (
    .clk(clk), .porN(porN), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .swResetReq(swResetReq), .coreRelease(coreRelease),
    .core0VecOff(core0VecOff), .core1VecOff(core1VecOff)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic        expErr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t VECS [NV] = '{
    // R1 reset values
    '{1'b0, 12'h100, 4'hF, 32'h0, 32'h1,        1'b0, 8'd1},
    '{1'b0, 12'h200, 4'hF, 32'h0, 32'h7F,       1'b0, 8'd1},
    '{1'b0, 12'h204, 4'hF, 32'h0, 32'h0,        1'b0, 8'd1},
    '{1'b0, 12'h218, 4'hF, 32'h0, 32'h0,        1'b0, 8'd1},
    '{1'b0, 12'h110, 4'hF, 32'h0, 32'h1000_0000,1'b0, 8'd1},
    '{1'b0, 12'h114, 4'hF, 32'h0, 32'h1000_2000,1'b0, 8'd1},
    '{1'b0, 12'h118, 4'hF, 32'h0, 32'h2,        1'b0, 8'd1},
    '{1'b0, 12'h120, 4'hF, 32'h0, 32'h1,        1'b0, 8'd1},
    // R7 identification words
    '{1'b0, 12'hFD0, 4'hF, 32'h0, 32'h04, 1'b0, 8'd7},
    '{1'b0, 12'hFDC, 4'hF, 32'h0, 32'h00, 1'b0, 8'd7},
    '{1'b0, 12'hFE0, 4'hF, 32'h0, 32'h54, 1'b0, 8'd7},
    '{1'b0, 12'hFE4, 4'hF, 32'h0, 32'hB8, 1'b0, 8'd7},
    '{1'b0, 12'hFE8, 4'hF, 32'h0, 32'h1B, 1'b0, 8'd7},
    '{1'b0, 12'hFF0, 4'hF, 32'h0, 32'h0D, 1'b0, 8'd7},
    '{1'b0, 12'hFFC, 4'hF, 32'h0, 32'hB1, 1'b0, 8'd7},
    // R9 plain words
    '{1'b1, 12'h014, 4'hF, 32'hDEAD_BEEF, 32'h0, 1'b0, 8'd9},
    '{1'b0, 12'h014, 4'hF, 32'h0, 32'hDEAD_BEEF, 1'b0, 8'd9},
    '{1'b1, 12'h104, 4'hF, 32'h0000_5A5A, 32'h0, 1'b0, 8'd9},
    '{1'b0, 12'h104, 4'hF, 32'h0, 32'h0000_5A5A, 1'b0, 8'd9},
    '{1'b1, 12'h11C, 4'hF, 32'h1, 32'h0, 1'b0, 8'd9},
    '{1'b0, 12'h11C, 4'hF, 32'h0, 32'h1, 1'b0, 8'd9},
    '{1'b1, 12'h20C, 4'hF, 32'h33, 32'h0, 1'b0, 8'd9},
    '{1'b0, 12'h20C, 4'hF, 32'h0, 32'h33, 1'b0, 8'd9},
    '{1'b1, 12'h10C, 4'hF, 32'h0000_CAFE, 32'h0, 1'b0, 8'd9},
    '{1'b0, 12'h10C, 4'hF, 32'h0, 32'h0000_CAFE, 1'b0, 8'd9},
    // R8 byte strobes
    '{1'b1, 12'h018, 4'hF, 32'h1122_3344, 32'h0, 1'b0, 8'd8},
    '{1'b1, 12'h018, 4'h2, 32'hAABB_CCDD, 32'h0, 1'b0, 8'd8},
    '{1'b0, 12'h018, 4'hF, 32'h0, 32'h0000_CC00, 1'b0, 8'd8},
    '{1'b0, 12'h014, 4'h1, 32'h0, 32'hDEAD_BEEF, 1'b0, 8'd8},
    // R3 debug set / clear
    '{1'b1, 12'h004, 4'hF, 32'hF0, 32'h0, 1'b0, 8'd3},
    '{1'b1, 12'h004, 4'hF, 32'h03, 32'h0, 1'b0, 8'd3},
    '{1'b0, 12'h000, 4'hF, 32'h0, 32'hF3, 1'b0, 8'd3},
    '{1'b1, 12'h008, 4'hF, 32'h11, 32'h0, 1'b0, 8'd3},
    '{1'b0, 12'h000, 4'hF, 32'h0, 32'hE2, 1'b0, 8'd3},
    // R11 write-only, unmapped and read-only
    '{1'b0, 12'h004, 4'hF, 32'h0, 32'h0, 1'b0, 8'd11},
    '{1'b0, 12'h208, 4'hF, 32'h0, 32'h0, 1'b1, 8'd11},
    '{1'b1, 12'h0FC, 4'hF, 32'h5, 32'h0, 1'b1, 8'd11},
    '{1'b1, 12'h000, 4'hF, 32'hFF, 32'h0, 1'b1, 8'd11},
    '{1'b0, 12'h000, 4'hF, 32'h0, 32'hE2, 1'b0, 8'd11},
    '{1'b1, 12'hFD0, 4'hF, 32'h77, 32'h0, 1'b1, 8'd11},
    '{1'b0, 12'hFD0, 4'hF, 32'h0, 32'h04, 1'b0, 8'd11},
    // R6 power-control lock
    '{1'b1, 12'h120, 4'hF, 32'h3, 32'h0, 1'b0, 8'd6},
    '{1'b0, 12'h120, 4'hF, 32'h0, 32'h3, 1'b0, 8'd6},
    '{1'b1, 12'h120, 4'hF, 32'h2, 32'h0, 1'b0, 8'd6},
    '{1'b0, 12'h120, 4'hF, 32'h0, 32'h2, 1'b0, 8'd6},
    '{1'b1, 12'h120, 4'hF, 32'h1, 32'h0, 1'b0, 8'd6},
    '{1'b0, 12'h120, 4'hF, 32'h0, 32'h2, 1'b0, 8'd6},
    // R2 core-0 vector lock
    '{1'b1, 12'h110, 4'hF, 32'h2000_0080, 32'h0, 1'b0, 8'd2},
    '{1'b0, 12'h110, 4'hF, 32'h0, 32'h2000_0080, 1'b0, 8'd2},
    '{1'b1, 12'h110, 4'hF, 32'h3000_00FF, 32'h0, 1'b0, 8'd2},
    '{1'b1, 12'h110, 4'hF, 32'h4000_0000, 32'h0, 1'b0, 8'd2},
    '{1'b0, 12'h110, 4'hF, 32'h0, 32'h3000_00FF, 1'b0, 8'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [3:0] b,
                     input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = w; busAddr = a; busBe = b; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic doReset(input logic withPor);
    @(negedge clk);
    rstN = 1'b0;
    if (withPor) porN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; porN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1; porN = 1'b1;
    @(negedge clk);

    // R1 outputs after reset
    chk("R1 rdata idle", busRdata, 32'h0);
    chk("R1 core0VecOff", core0VecOff, 32'h1000_0000);
    chk("R1 core1VecOff", core1VecOff, 32'h1000_2000);
    chk("R1 pulses", {30'b0, swResetReq, busErr}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].data);
      if (!VECS[i].wr)
        chk($sformatf("R%0d read %h", VECS[i].req, VECS[i].addr), busRdata, VECS[i].exp);
      chk($sformatf("R%0d err %h", VECS[i].req, VECS[i].addr), 32'(busErr), 32'(VECS[i].expErr));
    end

    // R2 offset output masks lock and low bits
    chk("R2 core0VecOff locked", core0VecOff, 32'h3000_0080);
    // R9 core-1 vector write reaches output
    acc(1'b1, 12'h114, 4'hF, 32'h0012_3400);
    chk("R9 core1VecOff", core1VecOff, 32'h0012_3400);

    // R12 timing: result after edge, idle returns 0
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 12'h200; busBe = 4'hF;
    #1 chk("R12 before edge", busRdata, 32'h0);
    @(negedge clk);
    busSel = 1'b0;
    chk("R12 after edge", busRdata, 32'h7F);
    @(negedge clk);
    chk("R12 idle again", busRdata, 32'h0);
    acc(1'b0, 12'h208, 4'hF, 32'h0);
    @(negedge clk);
    chk("R11 err one cycle", 32'(busErr), 32'h0);

    // R5 release strobes (hold reset = 2'b10)
    acc(1'b1, 12'h118, 4'hF, 32'h0);
    chk("R5 drop core1", 32'(coreRelease), 32'h2);
    @(negedge clk);
    chk("R5 pulse ends", 32'(coreRelease), 32'h0);
    acc(1'b1, 12'h118, 4'hF, 32'h3);
    chk("R5 raise no pulse", 32'(coreRelease), 32'h0);
    acc(1'b1, 12'h118, 4'hF, 32'h1);
    chk("R5 drop core1 only", 32'(coreRelease), 32'h2);
    acc(1'b1, 12'h118, 4'hF, 32'h0);
    chk("R5 drop core0", 32'(coreRelease), 32'h1);
    acc(1'b1, 12'h118, 4'hF, 32'h0);
    chk("R5 rewrite zero", 32'(coreRelease), 32'h0);

    // R4 software reset
    acc(1'b1, 12'h108, 4'hF, 32'h0000_0200);
    chk("R4 request", 32'(swResetReq), 32'h1);
    @(negedge clk);
    chk("R4 one cycle", 32'(swResetReq), 32'h0);
    acc(1'b1, 12'h108, 4'hF, 32'hFFFF_FDFF);
    chk("R4 other bits", 32'(swResetReq), 32'h0);
    acc(1'b1, 12'h108, 4'h1, 32'h0000_0200);
    chk("R4 lane off", 32'(swResetReq), 32'h0);
    acc(1'b0, 12'h108, 4'hF, 32'h0);
    chk("R4 reads zero", busRdata, 32'h0);

    // R10 warm reset keeps retention word, clears others and lock
    doReset(1'b0);
    acc(1'b0, 12'h10C, 4'hF, 32'h0);
    chk("R10 retained", busRdata, 32'h0000_CAFE);
    acc(1'b0, 12'h110, 4'hF, 32'h0);
    chk("R1 vec0 reloaded", busRdata, 32'h1000_0000);
    acc(1'b1, 12'h110, 4'hF, 32'h5000_0000);
    acc(1'b0, 12'h110, 4'hF, 32'h0);
    chk("R2 unlocked by reset", busRdata, 32'h5000_0000);
    doReset(1'b1);
    acc(1'b0, 12'h10C, 4'hF, 32'h0);
    chk("R10 cleared by power-on", busRdata, 32'h0);

    finish_run();
  end

endmodule